// File: doc/BRIEF.md
# Programmable Cross-Trigger Router

This block passes debug trigger events between a set of fixed trigger lines and a small group of shared event channels. Each channel runs in both directions toward a channel matrix. A rising edge on a trigger input becomes a one-cycle event on every channel that the input's channel mask selects, and that event is also sent out to the matrix. A trigger output fires when any channel in its own mask is active. An active channel is one driven locally or one that arrives from the matrix.

A small word-addressed register bank holds the routing. Offset 0 carries a global enable bit. The next NTRIG offsets carry the per-input channel masks, and the NTRIG offsets after those carry the per-output channel masks. Outputs whose destination returns an acknowledge are declared by a parameter and stay asserted until that acknowledge arrives. Every other output is a single-cycle pulse. Fan-out and merging follow directly from the masks: one input to many outputs, many inputs to one output, or any mix.

Top module: `xtrig_router`

## Requirements
- R1: After reset the enable bit and every mask read as zero, and `trigOut` and `chanOut` are low.
- R2: Register map, 4-bit data: offset 0 bit 0 is the global enable (bits 3:1 read 0). Offset 1+i holds the channel mask of trigger input i, and offset 9+i holds the channel mask of trigger output i (i = 0..7). A read returns the current value in the same cycle.
- R3: A write to any offset above 16 changes no register, and a read there returns zero.
- R4: Inputs are edge detected. A trigger input held high for many cycles produces one channel event. That event appears on `chanOut` for exactly one cycle, on the cycle after the clock edge that first samples the input high.
- R5: `chanOut[c]` is the OR over all inputs that rose and have bit c set in their input mask.
- R6: Trigger output o asserts on the cycle after any channel in its output mask is active. A channel is active when it is driven locally on `chanOut` or received on `chanIn`.
- R7: Outputs without an acknowledge (bit clear in ACK_PRESENT, default 8'h0C) give a one-cycle pulse per event.
- R8: An output with an acknowledge stays high until the edge that samples its `trigAck` bit high, and is low on the cycle after that edge. For outputs without an acknowledge, `trigAck` has no effect.
- R9: With the enable bit at 0, no trigger input produces a channel event and no channel activity asserts any trigger output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word offset |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data for regAddr |
| trigIn | input | 8 | Trigger inputs from attached components |
| trigAck | input | 8 | Acknowledges from output destinations |
| trigOut | output | 8 | Trigger outputs to attached components |
| chanIn | input | 4 | Channel events received from the matrix |
| chanOut | output | 4 | Channel events sent to the matrix |

## Verification
A wrong mask bit or a stuck enable shows at the ports within two cycles of a trigger edge. It appears either as a channel pattern on `chanOut` one cycle after the edge, or as a missing or extra bit on `trigOut` one cycle later. A broken edge detector shows as a repeated `chanOut` event on the cycles after the first while an input is held high. A broken hold path shows as an acknowledged output that drops early or stays high after its acknowledge. The register bank is checked by reading every written mask back, and by reading and writing an undefined offset.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int NTRIG    = 8;
  localparam int NCHAN    = 4;
  localparam int ADDR_W   = 5;
  localparam int IN_BASE  = 1;
  localparam int OUT_BASE = IN_BASE + NTRIG;
  localparam int LAST_OFF = OUT_BASE + NTRIG - 1;

  typedef logic [NCHAN-1:0] chanMask_t;

  typedef struct packed {
    logic                  routeEn;
    chanMask_t [NTRIG-1:0] inMask;
    chanMask_t [NTRIG-1:0] outMask;
  } routeCfg_t;
endpackage

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
  import xtrig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NCHAN-1:0]  regWrData,
  output logic [NCHAN-1:0]  regRdData,
  output routeCfg_t         cfg
);
  logic                  routeEnQ;
  chanMask_t [NTRIG-1:0] inMaskQ;
  chanMask_t [NTRIG-1:0] outMaskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeEnQ <= 1'b0;
      inMaskQ  <= '0;
      outMaskQ <= '0;
    end else if (regWrEn) begin
      if (regAddr == '0) routeEnQ <= regWrData[0];
      for (int i = 0; i < NTRIG; i++) begin
        if (regAddr == ADDR_W'(IN_BASE + i))  inMaskQ[i]  <= regWrData;
        if (regAddr == ADDR_W'(OUT_BASE + i)) outMaskQ[i] <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) regRdData[0] = routeEnQ;
    for (int i = 0; i < NTRIG; i++) begin
      if (regAddr == ADDR_W'(IN_BASE + i))  regRdData = inMaskQ[i];
      if (regAddr == ADDR_W'(OUT_BASE + i)) regRdData = outMaskQ[i];
    end
  end

  assign cfg.routeEn = routeEnQ;
  assign cfg.inMask  = inMaskQ;
  assign cfg.outMask = outMaskQ;

  // R3
  write_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr > ADDR_W'(LAST_OFF)) |=> $stable(cfg));
endmodule

// File: rtl/xtrig_datapath.sv
module xtrig_datapath
  import xtrig_pkg::*;
#(
  parameter logic [NTRIG-1:0] ACK_PRESENT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  routeCfg_t        cfg,
  input  logic [NTRIG-1:0] trigIn,
  input  logic [NTRIG-1:0] trigAck,
  input  chanMask_t        chanIn,
  output chanMask_t        chanOut,
  output logic [NTRIG-1:0] trigOut
);
  logic [NTRIG-1:0] trigInQ;
  logic [NTRIG-1:0] trigRise;
  logic [NTRIG-1:0] hit;
  logic [NTRIG-1:0] trigOutNext;
  chanMask_t        chanNext;
  chanMask_t        chanActive;
  logic             pastOk;

  assign trigRise   = trigIn & ~trigInQ;
  assign chanActive = chanOut | chanIn;

  always_comb begin
    chanNext = '0;
    if (cfg.routeEn) begin
      for (int i = 0; i < NTRIG; i++) begin
        if (trigRise[i]) chanNext = chanNext | cfg.inMask[i];
      end
    end
  end

  for (genvar o = 0; o < NTRIG; o++) begin : g_out
    assign hit[o] = cfg.routeEn & (|(chanActive & cfg.outMask[o]));
  end

  assign trigOutNext = hit | (trigOut & ACK_PRESENT & ~trigAck);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigInQ <= '0;
      chanOut <= '0;
      trigOut <= '0;
      pastOk  <= 1'b0;
    end else begin
      trigInQ <= trigIn;
      chanOut <= chanNext;
      trigOut <= trigOutNext;
      pastOk  <= 1'b1;
    end
  end

  // R9
  gate_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.routeEn |=> chanOut == '0);

  // R4
  level_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && trigIn == $past(trigIn)) |=> chanOut == '0);

  for (genvar o = 0; o < NTRIG; o++) begin : g_chk
    if (ACK_PRESENT[o]) begin : g_ack
      // R8
      ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (trigOut[o] && !trigAck[o]) |=> trigOut[o]);
    end else begin : g_pulse
      // R9
      gated_out_chk: assert property (@(posedge clk) disable iff (!rstN)
        (pastOk && trigOut[o]) |-> $past(cfg.routeEn));
    end
  end
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router
  import xtrig_pkg::*;
#(
  parameter logic [NTRIG-1:0] ACK_PRESENT = 8'b0000_1100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NCHAN-1:0]  regWrData,
  output logic [NCHAN-1:0]  regRdData,
  input  logic [NTRIG-1:0]  trigIn,
  input  logic [NTRIG-1:0]  trigAck,
  output logic [NTRIG-1:0]  trigOut,
  input  logic [NCHAN-1:0]  chanIn,
  output logic [NCHAN-1:0]  chanOut
);
  routeCfg_t cfg;

  xtrig_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cfg       (cfg)
  );

  xtrig_datapath #(.ACK_PRESENT(ACK_PRESENT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .trigIn  (trigIn),
    .trigAck (trigAck),
    .chanIn  (chanIn),
    .chanOut (chanOut),
    .trigOut (trigOut)
  );
endmodule

// File: tb/tb_xtrig_router.sv
module tb_xtrig_router;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [4:0] regAddr;
  logic [3:0] regWrData;
  logic [3:0] regRdData;
  logic [7:0] trigIn;
  logic [7:0] trigAck;
  logic [7:0] trigOut;
  logic [3:0] chanIn;
  logic [3:0] chanOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [7:0] tExp;
    logic [3:0] cExp;
    string      tag;
  } expItem_t;
  expItem_t sbq[$];

  xtrig_router dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trigIn(trigIn),
    .trigAck(trigAck), .trigOut(trigOut), .chanIn(chanIn), .chanOut(chanOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(int ofs, logic [7:0] t, logic [3:0] c, string tag);
    expItem_t it;
    it.at = cyc + ofs; it.tExp = t; it.cExp = c; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(logic [4:0] a, logic [3:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [3:0] exp, string tag);
    regAddr = a;
    #1;
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s read @%0d: actual %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  // monitor: pops expectations as their cycle comes up
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      nChecks++;
      if (sbq[0].at != cyc || trigOut !== sbq[0].tExp || chanOut !== sbq[0].cExp) begin
        nFails++;
        $display("FAIL %s cyc %0d: actual trigOut=%h chanOut=%h expected trigOut=%h chanOut=%h",
                 sbq[0].tag, cyc, trigOut, chanOut, sbq[0].tExp, sbq[0].cExp);
      end
      void'(sbq.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    trigIn = '0; trigAck = '0; chanIn = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    nChecks++;
    if (trigOut !== 8'h00 || chanOut !== 4'h0) begin
      nFails++;
      $display("FAIL R1 outputs: actual %h/%h expected 00/0", trigOut, chanOut);
    end
    rd(5'd0, 4'h0, "R1");
    rd(5'd1, 4'h0, "R1");
    rd(5'd16, 4'h0, "R1");

    // R9: routing configured but enable still 0
    wr(5'd1, 4'b0001);
    wr(5'd14, 4'b0001);
    trigIn = 8'h01;
    push(1, 8'h00, 4'h0, "R9 trig gated");
    push(2, 8'h00, 4'h0, "R9 trig gated");
    tick(); trigIn = 8'h00;
    repeat (3) tick();

    // R2 map and readback, upper data bits dropped on offset 0
    wr(5'd10, 4'b0001);
    wr(5'd0, 4'hF);
    rd(5'd0, 4'h1, "R2 enable");
    rd(5'd1, 4'h1, "R2 in0");
    rd(5'd14, 4'h1, "R2 out5");
    rd(5'd10, 4'h1, "R2 out1");

    // R5/R6/R7 one-to-many, single pulse
    tick();
    trigIn = 8'h01;
    push(1, 8'h00, 4'h1, "R5 fanout chan");
    push(2, 8'h22, 4'h0, "R6 fanout out");
    push(3, 8'h00, 4'h0, "R7 pulse end");
    tick(); trigIn = 8'h00;
    repeat (4) tick();

    // R4 level held: one event only
    trigIn = 8'h01;
    push(1, 8'h00, 4'h1, "R4 first event");
    push(2, 8'h22, 4'h0, "R4 no repeat");
    push(3, 8'h00, 4'h0, "R4 no repeat");
    push(4, 8'h00, 4'h0, "R4 no repeat");
    push(5, 8'h00, 4'h0, "R4 no repeat");
    repeat (6) tick();
    trigIn = 8'h00;
    repeat (2) tick();

    // R5/R6 many-to-one
    wr(5'd4, 4'b0010);
    wr(5'd15, 4'b0011);
    tick();
    trigIn = 8'h09;
    push(1, 8'h00, 4'h3, "R5 merge chan");
    push(2, 8'h62, 4'h0, "R6 merge out");
    push(3, 8'h00, 4'h0, "R7 merge end");
    tick(); trigIn = 8'h00;
    repeat (4) tick();

    // R6 event received from the matrix
    wr(5'd16, 4'b0100);
    tick();
    chanIn = 4'b0100;
    push(1, 8'h80, 4'h0, "R6 matrix in");
    push(2, 8'h00, 4'h0, "R7 matrix pulse");
    tick(); chanIn = 4'h0;
    repeat (3) tick();

    // R8 acknowledged output holds until ack
    wr(5'd11, 4'b1000);
    tick();
    chanIn = 4'b1000;
    push(1, 8'h04, 4'h0, "R8 set");
    push(2, 8'h04, 4'h0, "R8 hold");
    push(3, 8'h04, 4'h0, "R8 hold");
    tick(); chanIn = 4'h0;
    repeat (2) tick();
    trigAck = 8'h84;
    push(1, 8'h00, 4'h0, "R8 release");
    tick(); trigAck = 8'h00;
    repeat (2) tick();

    // R3 undefined offsets
    wr(5'd20, 4'hF);
    wr(5'd31, 4'hF);
    rd(5'd20, 4'h0, "R3 undefined read");
    rd(5'd0, 4'h1, "R3 enable kept");
    rd(5'd4, 4'h2, "R3 in3 kept");
    rd(5'd11, 4'h8, "R3 out2 kept");

    // R9 disable blocks both stages
    wr(5'd0, 4'h0);
    tick();
    chanIn = 4'b0100; trigIn = 8'h08;
    push(1, 8'h00, 4'h0, "R9 all gated");
    push(2, 8'h00, 4'h0, "R9 all gated");
    tick(); chanIn = 4'h0; trigIn = 8'h00;
    repeat (4) tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule